// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Array with Row Refresh

This block is a synthesizable behavioural model of a dynamic memory laid out as a square grid of 4-bit words. It does not have separate row and column address lines. One narrow address bus carries both, one after the other. The row address is taken when the row strobe is raised. Each column address is taken with a column strobe while that row stays open. A write-enable input chooses between storing the data input and reading. An output-enable input lets the read word appear on the data output one cycle later.

A refresh engine runs inside the block. A timer raises a refresh request at a fixed interval. When the request is granted, the engine copies one whole row into a holding register and writes it back. It then moves its row pointer to the next row and wraps after the last one. A refresh is granted only while the row strobe is low. A row strobe that arrives during a refresh waits until the writeback is done. The grid edge is set by the address width, so a test can use a small array.

Top module: `dram_mux_array`

## Requirements
- R1: The array holds 2^ADDR_W rows by 2^ADDR_W columns of DATA_W-bit words (4^ADDR_W words). It is addressed only through the ADDR_W-bit `addr` bus. Every row and column index, including 0 and the last one, reaches a distinct word.
- R2: If `row_strobe` is high at a clock edge while the block is idle (no open row and no refresh), `addr` is taken as the row address. The row stays open and keeps that address for as many column accesses as occur until `row_strobe` goes low.
- R3: If `col_strobe` and `wr_en` are both high at an edge while a row is open, `din` is stored at that row and at column `addr`, at that same edge. A later read of that location returns the new word.
- R4: If `col_strobe` and `out_en` are high and `wr_en` is low at an edge while a row is open, the addressed word is on `dout` with `dout_valid` high during the following cycle only.
- R5: In every other cycle, `dout` is all zeros and `dout_valid` is low. This includes a column read with `out_en` low.
- R6: A column strobe while no row is open is ignored. It neither stores data nor produces `dout_valid`.
- R7: A refresh request is raised every REFRESH_INTERVAL cycles. When the block is idle with `row_strobe` low, a pending request starts a refresh. The refresh holds `busy` high for exactly two cycles: one to read the row and one to write it back. Rows are refreshed in ascending order, wrapping after the last row. With the block idle, refreshes start exactly REFRESH_INTERVAL cycles apart.
- R8: No refresh starts while `row_strobe` is high. A request that is pending when the row closes starts a refresh at the second edge after `row_strobe` falls.
- R9: A `row_strobe` raised during a refresh does not open the row until the writeback is done. The row opens at the first edge after `busy` falls, and access then proceeds normally.
- R10: Refresh preserves contents. Words written earlier read back unchanged after every row has been refreshed several times.
- R11: Synchronous active-high `rst` returns the block to idle. After reset, `busy` is low, `dout` is zero and `dout_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Shared bus: row address with the row strobe, column address with the column strobe |
| row_strobe | input | 1 | High to open a row and keep it open; low closes it |
| col_strobe | input | 1 | High for one column access in the open row |
| wr_en | input | 1 | High makes a column access a write |
| out_en | input | 1 | High lets a column read drive `dout` |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not valid |
| dout_valid | output | 1 | High in the cycle after a column read |
| busy | output | 1 | High while a row refresh is in progress |

## Verification
The checker assumes that `row_strobe` stays low during reset. It also assumes that `wr_en`, `out_en` and `addr` are stable around each clock edge, so the cycle before a valid read really shows the strobe and enable levels that produced it. The bench drives every input at the falling edge and holds the row strobe high for the whole of each access. It raises the column strobe only for single cycles and clears the write and output enables as soon as the strobe drops. Some column strobes are sent with the row closed, but no input changes are timed against the rising edge.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_OPEN    = 2'd1,
        ST_RF_READ = 2'd2,
        ST_RF_WB   = 2'd3
    } dram_state_e;

    function automatic int grid_edge(input int aw);
        return 1 << aw;
    endfunction

    function automatic logic is_refreshing(input dram_state_e st);
        return (st == ST_RF_READ) || (st == ST_RF_WB);
    endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int ROWS             = 32,
    parameter int REFRESH_INTERVAL = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    done,
    output logic                    pending,
    output logic [$clog2(ROWS)-1:0] ptr
);
    localparam int CNT_W = (REFRESH_INTERVAL > 2) ? $clog2(REFRESH_INTERVAL) : 1;
    localparam int PTR_W = $clog2(ROWS);

    logic [CNT_W-1:0] cnt;
    logic             tick;

    assign tick = (cnt == CNT_W'(REFRESH_INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
            ptr     <= '0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick)
                pending <= 1'b1;
            else if (done)
                pending <= 1'b0;
            if (done)
                ptr <= (ptr == PTR_W'(ROWS - 1)) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/dram_row_store.sv
module dram_row_store #(
    parameter int ROWS     = 32,
    parameter int COLS     = 32,
    parameter int DATA_W   = 4
) (
    input  logic                       clk,
    input  logic [$clog2(ROWS)-1:0]    rd_idx,
    output logic [COLS*DATA_W-1:0]     rd_row,
    input  logic                       row_we,
    input  logic [$clog2(ROWS)-1:0]    row_idx,
    input  logic [COLS*DATA_W-1:0]     row_data,
    input  logic                       word_we,
    input  logic [$clog2(ROWS)-1:0]    word_row,
    input  logic [$clog2(COLS)-1:0]    word_col,
    input  logic [DATA_W-1:0]          word_data
);
    localparam int ROW_BITS = COLS * DATA_W;

    logic [ROW_BITS-1:0] cells [ROWS];

    assign rd_row = cells[rd_idx];

    always_ff @(posedge clk) begin
        if (row_we)
            cells[row_idx] <= row_data;
        else if (word_we)
            cells[word_row][int'(word_col)*DATA_W +: DATA_W] <= word_data;
    end
endmodule

// File: rtl/dram_mux_array.sv
module dram_mux_array
    import dram_mux_pkg::*;
#(
    parameter int ADDR_W           = 5,
    parameter int DATA_W           = 4,
    parameter int REFRESH_INTERVAL = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              row_strobe,
    input  logic              col_strobe,
    input  logic              wr_en,
    input  logic              out_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              busy
);
    localparam int ROWS     = grid_edge(ADDR_W);
    localparam int COLS     = grid_edge(ADDR_W);
    localparam int ROW_BITS = COLS * DATA_W;

    dram_state_e         state, state_d;
    logic [ADDR_W-1:0]   row_q;
    logic [ROW_BITS-1:0] rf_buf;
    logic [DATA_W-1:0]   dout_q;
    logic                valid_q;

    logic                ref_pending, ref_done;
    logic [ADDR_W-1:0]   ref_ptr;
    logic [ADDR_W-1:0]   rd_idx;
    logic [ROW_BITS-1:0] rd_row;
    logic [DATA_W-1:0]   words [COLS];
    logic                access_hit, do_write, do_read;

    // Split the selected row into column words
    for (genvar g = 0; g < COLS; g++) begin : g_col
        assign words[g] = rd_row[g*DATA_W +: DATA_W];
    end

    assign access_hit = (state == ST_OPEN) && row_strobe && col_strobe;
    assign do_write   = access_hit && wr_en;
    assign do_read    = access_hit && !wr_en && out_en;
    assign ref_done   = (state == ST_RF_WB);
    assign rd_idx     = (state == ST_OPEN) ? row_q : ref_ptr;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_pending && !row_strobe) state_d = ST_RF_READ;
                else if (row_strobe)            state_d = ST_OPEN;
            end
            ST_OPEN:    if (!row_strobe) state_d = ST_IDLE;
            ST_RF_READ: state_d = ST_RF_WB;
            ST_RF_WB:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            row_q   <= '0;
            rf_buf  <= '0;
            dout_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            state <= state_d;
            if (state == ST_IDLE && row_strobe)
                row_q <= addr;
            if (state == ST_RF_READ)
                rf_buf <= rd_row;
            dout_q  <= do_read ? words[addr] : '0;
            valid_q <= do_read;
        end
    end

    dram_refresh_timer #(
        .ROWS             (ROWS),
        .REFRESH_INTERVAL (REFRESH_INTERVAL)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .done    (ref_done),
        .pending (ref_pending),
        .ptr     (ref_ptr)
    );

    dram_row_store #(
        .ROWS   (ROWS),
        .COLS   (COLS),
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rd_idx    (rd_idx),
        .rd_row    (rd_row),
        .row_we    (ref_done),
        .row_idx   (ref_ptr),
        .row_data  (rf_buf),
        .word_we   (do_write),
        .word_row  (row_q),
        .word_col  (addr),
        .word_data (din)
    );

    assign dout       = dout_q;
    assign dout_valid = valid_q;
    assign busy       = is_refreshing(state);
endmodule

// File: rtl/dram_mux_checker.sv
module dram_mux_checker #(
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              row_strobe,
    input logic              col_strobe,
    input logic              wr_en,
    input logic              out_en,
    input logic              busy,
    input logic              dout_valid,
    input logic [DATA_W-1:0] dout
);
    AST_REFRESH_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy ##1 !busy);                                      // R7
    AST_REFRESH_NEEDS_ROW_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(row_strobe));                                  // R8
    AST_READ_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> ($past(col_strobe) && $past(out_en) && !$past(wr_en))); // R4
    AST_QUIET_DOUT: assert property (@(posedge clk) disable iff (rst)
        !dout_valid |-> (dout == '0));                                        // R5
    AST_READ_NEEDS_OPEN_ROW: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> ($past(row_strobe) && $past(row_strobe, 2) && !$past(busy))); // R6
    AST_NO_READ_DURING_REFRESH: assert property (@(posedge clk) disable iff (rst)
        busy |-> !dout_valid);                                                // R9
endmodule

bind dram_mux_array dram_mux_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .row_strobe (row_strobe),
    .col_strobe (col_strobe),
    .wr_en      (wr_en),
    .out_en     (out_en),
    .busy       (busy),
    .dout_valid (dout_valid),
    .dout       (dout)
);

// File: tb/dram_mux_array_test.sv
`timescale 1ns/1ps
module dram_mux_array_test;
    localparam int AW  = 3;
    localparam int DW  = 4;
    localparam int RI  = 16;
    localparam int NV  = 8;

    // vector: {row[2:0], col[2:0], data[3:0]}
    localparam logic [9:0] VEC [NV] = '{
        {3'd0, 3'd0, 4'h5}, {3'd7, 3'd7, 4'hA}, {3'd0, 3'd7, 4'h3},
        {3'd7, 3'd0, 4'hC}, {3'd3, 3'd4, 4'hF}, {3'd4, 3'd3, 4'h0},
        {3'd1, 3'd2, 4'h9}, {3'd6, 3'd5, 4'h6}
    };

    logic          clk = 0;
    logic          rst = 1;
    logic [AW-1:0] addr = '0;
    logic          row_strobe = 0, col_strobe = 0, wr_en = 0, out_en = 0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_valid, busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dram_mux_array #(.ADDR_W(AW), .DATA_W(DW), .REFRESH_INTERVAL(RI)) uut (
        .clk(clk), .rst(rst), .addr(addr), .row_strobe(row_strobe),
        .col_strobe(col_strobe), .wr_en(wr_en), .out_en(out_en), .din(din),
        .dout(dout), .dout_valid(dout_valid), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic open_row(input logic [AW-1:0] r);
        addr = r;
        row_strobe = 1;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic col_access(input logic [AW-1:0] c, input logic we,
                              input logic oe, input logic [DW-1:0] d);
        addr = c; col_strobe = 1; wr_en = we; out_en = oe; din = d;
        @(negedge clk);
        col_strobe = 0; wr_en = 0; out_en = 0;
    endtask

    task automatic close_row();
        row_strobe = 0;
        @(negedge clk);
    endtask

    task automatic read_back(input logic [AW-1:0] r, input logic [AW-1:0] c,
                             input logic [DW-1:0] exp, input string req);
        open_row(r);
        col_access(c, 1'b0, 1'b1, '0);
        chk(req, int'(dout_valid), 1);
        chk(req, int'(dout), int'(exp));
        close_row();
        chk({req, "/R5 idle after read"}, int'({dout_valid, dout}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 busy after reset", int'(busy), 0);
        chk("R11 dout after reset", int'(dout), 0);
        chk("R11 valid after reset", int'(dout_valid), 0);
        rst = 0;
        @(negedge clk);

        // Table walk: write every vector, then read every vector
        for (int i = 0; i < NV; i++) begin
            open_row(VEC[i][9:7]);
            col_access(VEC[i][6:4], 1'b1, 1'b0, VEC[i][3:0]);
            chk("R5 no valid on write", int'(dout_valid), 0);
            close_row();
        end
        for (int i = 0; i < NV; i++)
            read_back(VEC[i][9:7], VEC[i][6:4], VEC[i][3:0], "R1/R3/R4 table");

        // R2: row stays latched across several column accesses
        open_row(3'd2);
        col_access(3'd1, 1'b1, 1'b0, 4'h5);
        col_access(3'd6, 1'b1, 1'b0, 4'hA);
        col_access(3'd1, 1'b0, 1'b1, '0);
        chk("R2 same row col1", int'(dout), 5);
        col_access(3'd6, 1'b0, 1'b1, '0);
        chk("R2 same row col6", int'(dout), 10);
        // R5: read with output enable low
        col_access(3'd6, 1'b0, 1'b0, '0);
        chk("R5 oe low valid", int'(dout_valid), 0);
        chk("R5 oe low dout", int'(dout), 0);
        close_row();

        // R6: column strobes with no open row
        addr = VEC[0][6:4]; col_strobe = 1; wr_en = 1; din = ~VEC[0][3:0];
        @(negedge clk);
        col_strobe = 0; wr_en = 0;
        chk("R6 no valid without row", int'(dout_valid), 0);
        col_strobe = 1; out_en = 1;
        @(negedge clk);
        col_strobe = 0; out_en = 0;
        chk("R6 no read without row", int'(dout_valid), 0);
        read_back(VEC[0][9:7], VEC[0][6:4], VEC[0][3:0], "R6 data kept");

        // R7: refresh duration and period while idle
        begin
            int guard = 0;
            int hi = 0;
            int per = 0;
            logic prevb = busy;
            while (!(busy && !prevb) && guard < 100) begin
                prevb = busy; @(negedge clk); guard++;
            end
            while (busy && hi < 100) begin
                @(negedge clk); hi++;
            end
            chk("R7 busy width", hi, 2);
            per = hi;
            prevb = busy;
            while (!(busy && !prevb) && per < 100) begin
                prevb = busy; @(negedge clk); per++;
            end
            chk("R7 refresh period", per, RI);
        end

        // R8: no refresh while the row strobe is high
        begin
            int seen = 0;
            open_row(VEC[4][9:7]);
            for (int k = 0; k < 3 * RI; k++) begin
                @(negedge clk);
                if (busy) seen++;
            end
            chk("R8 no refresh with row open", seen, 0);
            close_row();
            chk("R8 closing cycle not busy", int'(busy), 0);
            @(negedge clk);
            chk("R8 refresh starts after close", int'(busy), 1);
        end

        // R9: row strobe raised during refresh is held off
        addr = VEC[1][9:7]; row_strobe = 1;
        @(negedge clk);
        chk("R9 still refreshing", int'(busy), 1);
        @(negedge clk);
        chk("R9 refresh done", int'(busy), 0);
        @(negedge clk);
        col_access(VEC[1][6:4], 1'b0, 1'b1, '0);
        chk("R9 read after hold-off valid", int'(dout_valid), 1);
        chk("R9 read after hold-off data", int'(dout), int'(VEC[1][3:0]));
        close_row();

        // R10: contents survive many full refresh sweeps
        repeat (RI * (1 << AW) * 3) @(negedge clk);
        for (int i = 1; i < NV; i++)
            read_back(VEC[i][9:7], VEC[i][6:4], VEC[i][3:0], "R10 retention");
        read_back(3'd2, 3'd1, 4'h5, "R10 retention row2");

        // R11: reset mid-access clears outputs
        open_row(3'd0);
        addr = 3'd0; col_strobe = 1; out_en = 1; rst = 1;
        @(negedge clk);
        col_strobe = 0; out_en = 0; row_strobe = 0;
        chk("R11 reset valid", int'(dout_valid), 0);
        chk("R11 reset busy", int'(busy), 0);
        rst = 0;
        @(negedge clk);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule